// File: doc/BRIEF.md
# Disk Sector Preamble Frame Synchronizer

This block sits behind a disk read channel that has already recovered the bit clock and turned the recorded flux pattern into plain NRZ bits. Each bit comes with a one-cycle strobe on a fast system clock. The block searches that serial stream for the sector preamble: a long run of zero bits closed by a single one bit. The one bit marks the word boundary. From the bit after it, the block slices the stream into 16-bit words.

Every sector holds two framed regions, and the block locks twice per sector. The first preamble opens a short header frame. When the header word count is reached, the block deliberately drops lock. It then ignores whatever follows, because the gap after the header can hold malformed pulses. It hunts again, and the second preamble opens the data frame. The data frame also carries its trailing check word. After the data frame the block returns to hunting for the next sector's header.

Each emitted word carries several flags. One marks the frame as header or data. The others mark the first and the last word of the frame. A two-bit phase output shows which of the four sequencing states is active. CRC checking, clock recovery, host transfer and storage are left to neighbouring logic.

Top module: `sector_frame_sync`

## Requirements
- R1: While hunting, the block locks when a strobed one bit arrives after at least RUN_LEN (default 31) consecutive strobed zero bits. The `phase` output shows the new state on the clock edge after the edge that samples that one bit.
- R2: A strobed one bit that arrives before RUN_LEN zeros have been collected restarts the zero count. A one bit after 30 zeros therefore does not lock, and neither does a later one bit after a shorter run.
- R3: Words are packed least significant bit first: the first bit after the sync bit goes to bit 0 of `word_data`, and the sixteenth goes to bit 15. `word_valid` pulses for one cycle, on the clock edge after the edge that samples the sixteenth bit.
- R4: The first lock of a sector yields exactly HDR_WORDS words with `frame_is_data`=0. `frame_start` is set on the first of them and `frame_end` on the last. After the last word, `phase` moves to hunt-for-data.
- R5: Outside a locked frame, no word is emitted and `word_data` reads zero. The block treats preamble-like bit patterns inside a locked frame as ordinary data and does not re-lock on them.
- R6: The lock made from hunt-for-data yields exactly DATA_WORDS words with `frame_is_data`=1, including the trailing check word. It uses the same start and end marking. After the last word, `phase` returns to hunt-for-header.
- R7: If IDLE_LIMIT consecutive clocks pass without a bit strobe, the block returns to hunt-for-header and forgets any partial zero run.
- R8: Synchronous reset sets `phase` to hunt-for-header, clears `word_valid` and `word_data`, and discards any zero run collected before it.
- R9: `bit_in` is ignored in any cycle where `bit_valid` is low.
- R10: `phase` encoding: 0 = hunt-for-header, 1 = header frame, 2 = hunt-for-data, 3 = data frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | One-cycle strobe marking a new serial bit |
| bit_in | input | 1 | Decoded NRZ bit, sampled when bit_valid is high |
| word_valid | output | 1 | One-cycle pulse: word_data holds a framed word |
| word_data | output | 16 | Assembled word, LSB received first; zero when word_valid is low |
| frame_is_data | output | 1 | 1 for a data-frame word, 0 for a header word |
| frame_start | output | 1 | Set with the first word of a frame |
| frame_end | output | 1 | Set with the last word of a frame |
| phase | output | 2 | Sequencing state, encoded as in R10 |

## Verification
The sync bit and the sixteenth bit of each word are each sampled on the rising edge where their strobe is high. Phase changes and word pulses become visible on the next edge, one clock later. The bench drives each strobe at a falling edge and holds the strobe low for three clocks after it. It reads `phase` only after that gap has passed. A monitor compares every `word_valid` pulse at a falling edge against a queue of expected words, which the driver fills before it sends each word's bits. Any word that arrives with an empty queue counts as a failure, so words emitted while unlocked are caught. The idle timeout is checked only after a gap longer than IDLE_LIMIT clocks.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        PH_HUNT_HDR  = 2'd0,
        PH_HEADER    = 2'd1,
        PH_HUNT_DATA = 2'd2,
        PH_DATA      = 2'd3
    } phase_e;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
        logic              is_data;
        logic              first;
        logic              last;
    } word_beat_t;

    function automatic phase_e phase_after(phase_e p);
        case (p)
            PH_HUNT_HDR:  return PH_HEADER;
            PH_HEADER:    return PH_HUNT_DATA;
            PH_HUNT_DATA: return PH_DATA;
            default:      return PH_HUNT_HDR;
        endcase
    endfunction

    function automatic logic phase_locked(phase_e p);
        return (p == PH_HEADER) || (p == PH_DATA);
    endfunction

endpackage

// File: rtl/zero_run_detector.sv
module zero_run_detector #(
    parameter int RUN_LEN = 31
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bit_valid,
    input  logic bit_in,
    output logic sync_hit
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);

    logic [CNT_W-1:0] zeros_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            zeros_q <= '0;
        end else if (bit_valid) begin
            if (bit_in)
                zeros_q <= '0;
            else if (zeros_q != CNT_W'(RUN_LEN))
                zeros_q <= zeros_q + 1'b1;
        end
    end

    assign sync_hit = bit_valid && bit_in && (zeros_q == CNT_W'(RUN_LEN));

    // R2: a hit needs the run counter full, which a strobed one always empties
    assert_run_restart_R2: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && bit_in) |=> (zeros_q == '0));

endmodule

// File: rtl/word_slicer.sv
module word_slicer
    import fsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              word_done,
    output logic [WORD_W-1:0] word_next
);
    localparam int BIT_W = $clog2(WORD_W);

    logic [WORD_W-1:0] shift_q;
    logic [BIT_W-1:0]  bitpos_q;

    always_ff @(posedge clk) begin
        if (rst)
            shift_q <= '0;
        else if (bit_valid)
            shift_q <= word_next;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable)
            bitpos_q <= '0;
        else if (bit_valid)
            bitpos_q <= (bitpos_q == BIT_W'(WORD_W - 1)) ? '0 : bitpos_q + 1'b1;
    end

    assign word_next = {bit_in, shift_q[WORD_W-1:1]};
    assign word_done = enable && bit_valid && (bitpos_q == BIT_W'(WORD_W - 1));

    // R3: the bit position only advances on a strobe while locked
    assert_pos_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (enable && !bit_valid) |=> $stable(bitpos_q));

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
    import fsync_pkg::*;
#(
    parameter int HDR_WORDS  = 3,
    parameter int DATA_WORDS = 129,
    parameter int IDLE_LIMIT = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              sync_hit,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word_next,
    output phase_e            phase,
    output logic              timeout,
    output word_beat_t        beat
);
    localparam int MAX_WORDS = (HDR_WORDS > DATA_WORDS) ? HDR_WORDS : DATA_WORDS;
    localparam int WCNT_W    = $clog2(MAX_WORDS + 1);
    localparam int IDLE_W    = $clog2(IDLE_LIMIT + 1);

    phase_e            phase_q;
    logic [WCNT_W-1:0] wcnt_q;
    logic [IDLE_W-1:0] idle_q;
    logic              last_word;

    assign timeout   = !bit_valid && (idle_q == IDLE_W'(IDLE_LIMIT - 1));
    assign last_word = (phase_q == PH_DATA) ? (wcnt_q == WCNT_W'(DATA_WORDS - 1))
                                            : (wcnt_q == WCNT_W'(HDR_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst || bit_valid)
            idle_q <= '0;
        else if (idle_q != IDLE_W'(IDLE_LIMIT))
            idle_q <= idle_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HUNT_HDR;
            wcnt_q  <= '0;
            beat    <= '0;
        end else begin
            beat <= '0;
            if (timeout) begin
                phase_q <= PH_HUNT_HDR;
                wcnt_q  <= '0;
            end else begin
                case (phase_q)
                    PH_HUNT_HDR, PH_HUNT_DATA: begin
                        wcnt_q <= '0;
                        if (sync_hit)
                            phase_q <= phase_after(phase_q);
                    end
                    default: begin
                        if (word_done) begin
                            beat.valid   <= 1'b1;
                            beat.data    <= word_next;
                            beat.is_data <= (phase_q == PH_DATA);
                            beat.first   <= (wcnt_q == '0);
                            beat.last    <= last_word;
                            if (last_word) begin
                                phase_q <= phase_after(phase_q);
                                wcnt_q  <= '0;
                            end else begin
                                wcnt_q <= wcnt_q + 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    assign phase = phase_q;

    // R5: words only follow a cycle in a locked phase
    assert_word_locked_R5: assert property (@(posedge clk) disable iff (rst)
        beat.valid |-> phase_locked($past(phase_q)));

    // R5: data bus is zero between words
    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !beat.valid |-> (beat.data == '0));

    // R4: phase moves only to its successor or back to header hunt
    assert_phase_order_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q != $past(phase_q)) |->
            (phase_q == phase_after($past(phase_q)) || phase_q == PH_HUNT_HDR));

    // R1: leaving a hunt phase for a locked one needs a strobed one bit
    assert_lock_on_one_R1: assert property (@(posedge clk) disable iff (rst)
        (phase_locked(phase_q) && !phase_locked($past(phase_q))) |->
            $past(bit_valid && bit_in));

    // R4: frame markers ride only on a valid word
    assert_marks_on_valid_R4: assert property (@(posedge clk) disable iff (rst)
        (beat.first || beat.last) |-> beat.valid);

    // R6: data-frame flag matches the phase that produced the word
    assert_data_flag_R6: assert property (@(posedge clk) disable iff (rst)
        beat.valid |-> (beat.is_data == ($past(phase_q) == PH_DATA)));

endmodule

// File: rtl/sector_frame_sync.sv
module sector_frame_sync
    import fsync_pkg::*;
#(
    parameter int HDR_WORDS  = 3,
    parameter int DATA_WORDS = 129,
    parameter int RUN_LEN    = 31,
    parameter int IDLE_LIMIT = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_valid,
    input  logic        bit_in,
    output logic        word_valid,
    output logic [15:0] word_data,
    output logic        frame_is_data,
    output logic        frame_start,
    output logic        frame_end,
    output logic [1:0]  phase
);
    logic              sync_hit;
    logic              timeout;
    logic              word_done;
    logic [WORD_W-1:0] word_next;
    phase_e            phase_s;
    word_beat_t        beat;

    zero_run_detector #(.RUN_LEN(RUN_LEN)) u_detect (
        .clk       (clk),
        .rst       (rst),
        .clear     (timeout),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .sync_hit  (sync_hit)
    );

    word_slicer u_slice (
        .clk       (clk),
        .rst       (rst),
        .enable    (phase_locked(phase_s)),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .word_done (word_done),
        .word_next (word_next)
    );

    frame_sequencer #(
        .HDR_WORDS  (HDR_WORDS),
        .DATA_WORDS (DATA_WORDS),
        .IDLE_LIMIT (IDLE_LIMIT)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .sync_hit  (sync_hit),
        .word_done (word_done),
        .word_next (word_next),
        .phase     (phase_s),
        .timeout   (timeout),
        .beat      (beat)
    );

    assign word_valid    = beat.valid;
    assign word_data     = beat.data;
    assign frame_is_data = beat.is_data;
    assign frame_start   = beat.first;
    assign frame_end     = beat.last;
    assign phase         = phase_s;

endmodule

// File: tb/sector_frame_sync_test.sv
module sector_frame_sync_test;

    localparam int HDR_N  = 3;
    localparam int DATA_N = 129;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        word_valid;
    logic [15:0] word_data;
    logic        frame_is_data;
    logic        frame_start;
    logic        frame_end;
    logic [1:0]  phase;

    int checks = 0;
    int errors = 0;
    logic [18:0] expq[$];

    always #2 clk = ~clk;

    sector_frame_sync uut (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
        .word_valid(word_valid), .word_data(word_data),
        .frame_is_data(frame_is_data), .frame_start(frame_start),
        .frame_end(frame_end), .phase(phase)
    );

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R9: bit_in carries the opposite value while the strobe is low
    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in = b;
        bit_valid = 1'b1;
        @(negedge clk);
        bit_valid = 1'b0;
        bit_in = ~b;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    task automatic send_word(input logic [15:0] w, input logic isd, input logic st,
                             input logic en, input logic expect_out);
        if (expect_out) expq.push_back({w, isd, st, en});
        for (int i = 0; i < 16; i++) send_bit(w[i]);
    endtask

    function automatic logic [15:0] data_pattern(input int i);
        if (i >= 4 && i <= 6) return 16'h0000;
        if (i == 7) return 16'h0001;
        return 16'(i) * 16'h0107 ^ 16'hA5C3;
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && word_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R5 unexpected word", {word_data, frame_is_data, frame_start, frame_end}, 0);
            end else begin
                logic [18:0] e;
                e = expq.pop_front();
                check({word_data, frame_is_data, frame_start, frame_end} == e,
                      e[2] ? "R6/R3 data word" : "R4/R3 header word",
                      {word_data, frame_is_data, frame_start, frame_end}, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check(phase == 2'd0, "R8 phase after reset", phase, 0);
        check(word_valid == 1'b0, "R8 word_valid after reset", word_valid, 0);
        check(word_data == 16'h0, "R8 word_data after reset", word_data, 0);
        rst = 1'b0;

        // R2: one bit after 30 zeros does not lock; shorter run after it neither
        send_zeros(30);
        send_bit(1'b1);
        check(phase == 2'd0, "R2 30 zeros then one", phase, 0);
        send_zeros(20);
        send_bit(1'b1);
        check(phase == 2'd0, "R2 restarted run too short", phase, 0);

        // R1: exactly 31 zeros then one locks into header (R10 code 1)
        send_zeros(31);
        send_bit(1'b1);
        check(phase == 2'd1, "R1 lock to header", phase, 1);

        // R4 header frame, R3 LSB-first
        send_word(16'h1234, 1'b0, 1'b1, 1'b0, 1'b1);
        send_word(16'h0000, 1'b0, 1'b0, 1'b0, 1'b1);
        send_word(16'h8001, 1'b0, 1'b0, 1'b1, 1'b1);
        repeat (2) @(negedge clk);
        check(phase == 2'd2, "R4 hunt for data after header", phase, 2);

        // R5: gap garbage produces nothing
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        send_zeros(5); send_bit(1'b1);
        check(phase == 2'd2, "R5 garbage keeps hunting", phase, 2);

        // R6: data preamble and data frame (contains a preamble-like run, R5)
        send_zeros(31);
        send_bit(1'b1);
        check(phase == 2'd3, "R6 lock to data", phase, 3);
        for (int i = 0; i < DATA_N; i++)
            send_word(data_pattern(i), 1'b1, i == 0, i == DATA_N - 1, 1'b1);
        repeat (2) @(negedge clk);
        check(phase == 2'd0, "R6 back to header hunt", phase, 0);
        check(expq.size() == 0, "R6 all data words seen", expq.size(), 0);

        // R7: loss of stream while locked
        send_zeros(31);
        send_bit(1'b1);
        send_word(16'hBEEF, 1'b0, 1'b1, 1'b0, 1'b1);
        repeat (300) @(negedge clk);
        check(phase == 2'd0, "R7 idle timeout to hunt", phase, 0);
        send_word(16'h5A5A, 1'b0, 1'b0, 1'b0, 1'b0);
        check(phase == 2'd0, "R7 no words after timeout", phase, 0);

        // R8: reset discards a partial zero run
        send_bit(1'b1);
        send_zeros(25);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        send_zeros(10);
        send_bit(1'b1);
        check(phase == 2'd0, "R8 run cleared by reset", phase, 0);
        send_zeros(31);
        send_bit(1'b1);
        check(phase == 2'd1, "R1 lock after reset", phase, 1);

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R5 scoreboard drained", expq.size(), 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule